// File: doc/BRIEF.md
# Programmable Waveform Bus Master

This block drives an external parallel bus from a small table of loadable waveform vectors. Each vector is one state of a waveform. It fixes the levels of six control outputs for as long as the state is active. It tests a chosen set of six ready inputs against required levels, either all of them or any of them. It picks the next state from two branch targets. When its condition is met, a vector may also pulse a FIFO advance strobe, step the 9-bit bus address, or mark the end of one transaction.

Software loads the eight vectors, a 32-bit transaction count, a start address and a transfer direction through a simple register port, then writes the go bit. The sequencer starts at vector 0 and repeats the waveform once per transaction until the count reaches zero. It then stops and raises done. A vector that needs the FIFO while the FIFO cannot serve it holds the waveform unchanged until the FIFO is ready again. The transfer direction decides whether an empty FIFO or a full FIFO causes the hold. Reading the count during a run returns the transactions that remain.

Top module: `wfm_master`

## Requirements
- R1: After reset, ctlOut, addrOut, fifoStrobe, busy and done are 0, and every register reads 0.
- R2: A write to register addresses 0 to 7 stores vector N. Reading that address returns the low 28 bits, with bits 31:28 read as 0. Vector fields, from low to high bits, are: ctl [5:0], mask [11:6], level [17:12], anyMode [18], nextTrue [21:19], nextFalse [24:22], fifoAdv [25], addrInc [26], last [27].
- R3: Writing bit 0 set to register 9 while idle with a nonzero count starts a run. From the next cycle busy is 1 and ctlOut shows the ctl field of the current vector, starting with vector 0. While idle, ctlOut is 0.
- R4: With anyMode 0, the condition is true when every rdyIn bit selected by mask equals the matching level bit. A mask of 0 is therefore always true. A true condition moves to nextTrue and a false one moves to nextFalse.
- R5: With anyMode 1, the condition is true when at least one masked rdyIn bit equals its level bit.
- R6: A vector whose addrInc is set and whose condition is true, and which is not stalled, increments addrOut by one in the next cycle, wrapping from 511 to 0. Register 10 loads the start address and reads it back.
- R7: fifoStrobe is 1 in exactly those cycles in which the current vector has fifoAdv set, its condition is true, and it is not stalled.
- R8: Register 9 bit 1 selects the direction: 0 sends data out, 1 brings data in. A true-condition vector with fifoAdv set stalls while fifoEmpty is high (direction 0) or fifoFull is high (direction 1). A stall changes no state, no address and no count.
- R9: A true, unstalled vector with last set decrements the count. If the count reaches zero, busy falls and done rises. Otherwise execution restarts at vector 0.
- R10: Register 8 reads the transactions still remaining, including during a run.
- R11: A go write with a count of 0 sets done without starting a run.
- R12: While busy, writes to registers 8, 9 and 10 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address (0-7 vectors, 8 count, 9 control/status, 10 address) |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr; status reads bit0 busy, bit1 done, bit2 direction |
| rdyIn | input | 6 | Ready inputs tested by vectors |
| fifoEmpty | input | 1 | FIFO has no data to send |
| fifoFull | input | 1 | FIFO cannot accept data |
| ctlOut | output | 6 | Control output levels |
| addrOut | output | 9 | Bus address |
| fifoStrobe | output | 1 | Advance the FIFO by one word |
| busy | output | 1 | Waveform running |
| done | output | 1 | Transaction count expired |

## Verification
The embedded properties check, cycle by cycle, the following rules:
- a go write starts at vector 0;
- a stall freezes the state index;
- the FIFO strobe never fires into a FIFO that cannot serve it;
- done and busy are never high together;
- the address and the count each step by exactly one when their strobes fire.

Branch selection under AND and OR conditions, restarts from vector 0, the 511-to-0 address wrap, and the remaining count read during a run can only be seen by running programs against the bench's reference model. The same holds for writes that are ignored while busy.

// File: rtl/wfm_pkg.sv
package wfm_pkg;
  localparam int CTL_W   = 6;
  localparam int RDY_W   = 6;
  localparam int ADDR_W  = 9;
  localparam int CNT_W   = 32;
  localparam int NUM_VEC = 8;
  localparam int IDX_W   = $clog2(NUM_VEC);
  localparam int REG_W   = 32;
  localparam int RA_W    = 4;
  localparam int VEC_W   = CTL_W + 2 * RDY_W + 2 * IDX_W + 4;

  localparam logic [RA_W-1:0] RA_COUNT = 4'd8;
  localparam logic [RA_W-1:0] RA_CTRL  = 4'd9;
  localparam logic [RA_W-1:0] RA_ADDR  = 4'd10;

  typedef struct packed {
    logic             last;
    logic             addrInc;
    logic             fifoAdv;
    logic [IDX_W-1:0] nextFalse;
    logic [IDX_W-1:0] nextTrue;
    logic             anyMode;
    logic [RDY_W-1:0] level;
    logic [RDY_W-1:0] mask;
    logic [CTL_W-1:0] ctl;
  } vec_t;

  typedef struct packed {
    logic cntLoad;
    logic cntDec;
    logic adrLoad;
    logic adrInc;
  } dp_strobe_t;
endpackage

// File: rtl/wfm_datapath.sv
module wfm_datapath
  import wfm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        strobe,
  input  logic [REG_W-1:0]  wrData,
  output logic [CNT_W-1:0]  cntQ,
  output logic [ADDR_W-1:0] addrQ,
  output logic              cntOne,
  output logic              cntZero
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strobe.cntLoad) begin
      cntQ <= CNT_W'(wrData);
    end else if (strobe.cntDec) begin
      cntQ <= cntQ - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
    end else if (strobe.adrLoad) begin
      addrQ <= wrData[ADDR_W-1:0];
    end else if (strobe.adrInc) begin
      addrQ <= addrQ + 1'b1;
    end
  end

  assign cntOne  = (cntQ == CNT_W'(1));
  assign cntZero = (cntQ == '0);

  p_addr_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.adrInc |=> addrQ == ADDR_W'($past(addrQ) + 1'b1));

  p_count_dec_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntDec |=> cntQ == CNT_W'($past(cntQ) - 1'b1));
endmodule

// File: rtl/wfm_ctrl.sv
module wfm_ctrl
  import wfm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic [RA_W-1:0]  regAddr,
  input  logic [REG_W-1:0] regWrData,
  input  logic [RDY_W-1:0] rdyIn,
  input  logic             fifoEmpty,
  input  logic             fifoFull,
  input  logic             cntOne,
  input  logic             cntZero,
  output dp_strobe_t       strobe,
  output logic [CTL_W-1:0] ctlOut,
  output logic             fifoStrobe,
  output logic             busy,
  output logic             done,
  output logic             dirIn,
  output logic [VEC_W-1:0] vecRdData
);
  logic             running;
  logic             doneQ;
  logic             dirQ;
  logic [IDX_W-1:0] idx;
  vec_t             tab [NUM_VEC];
  vec_t             cur;
  logic             tabSel;

  assign tabSel = regWr && (regAddr[RA_W-1:IDX_W] == '0);

  for (genvar i = 0; i < NUM_VEC; i++) begin : g_vec
    vec_t entry;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        entry <= '0;
      end else if (tabSel && regAddr[IDX_W-1:0] == IDX_W'(i)) begin
        entry <= vec_t'(regWrData[VEC_W-1:0]);
      end
    end
    assign tab[i] = entry;
  end

  assign cur       = tab[idx];
  assign vecRdData = tab[regAddr[IDX_W-1:0]];

  logic [RDY_W-1:0] hit;
  logic cond, fifoOk, stall, fire, ctrlWr, goReq;

  assign hit    = ~(rdyIn ^ cur.level) & cur.mask;
  assign cond   = cur.anyMode ? (|hit) : (&(hit | ~cur.mask));
  assign fifoOk = dirQ ? !fifoFull : !fifoEmpty;
  assign stall  = running && cond && cur.fifoAdv && !fifoOk;
  assign fire   = running && cond && !stall;
  assign ctrlWr = regWr && (regAddr == RA_CTRL) && !running;
  assign goReq  = ctrlWr && regWrData[0];

  always_comb begin
    strobe.cntLoad = regWr && (regAddr == RA_COUNT) && !running;
    strobe.adrLoad = regWr && (regAddr == RA_ADDR) && !running;
    strobe.adrInc  = fire && cur.addrInc;
    strobe.cntDec  = fire && cur.last;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      doneQ   <= 1'b0;
      dirQ    <= 1'b0;
      idx     <= '0;
    end else if (ctrlWr) begin
      dirQ <= regWrData[1];
      if (regWrData[0]) begin
        if (cntZero) begin
          doneQ <= 1'b1;
        end else begin
          running <= 1'b1;
          idx     <= '0;
          doneQ   <= 1'b0;
        end
      end
    end else if (running) begin
      if (!cond) begin
        idx <= cur.nextFalse;
      end else if (!stall) begin
        if (cur.last) begin
          idx <= '0;
          if (cntOne) begin
            running <= 1'b0;
            doneQ   <= 1'b1;
          end
        end else begin
          idx <= cur.nextTrue;
        end
      end
    end
  end

  assign ctlOut     = running ? cur.ctl : '0;
  assign fifoStrobe = fire && cur.fifoAdv;
  assign busy       = running;
  assign done       = doneQ;
  assign dirIn      = dirQ;

  p_go_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    (goReq && !cntZero) |=> (busy && idx == '0));

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> ($stable(idx) && busy));

  p_strobe_ready_r7: assert property (@(posedge clk) disable iff (!rstN)
    fifoStrobe |-> (dirQ ? !fifoFull : !fifoEmpty));

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
endmodule

// File: rtl/wfm_master.sv
module wfm_master
  import wfm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [RA_W-1:0]   regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic [RDY_W-1:0]  rdyIn,
  input  logic              fifoEmpty,
  input  logic              fifoFull,
  output logic [CTL_W-1:0]  ctlOut,
  output logic [ADDR_W-1:0] addrOut,
  output logic              fifoStrobe,
  output logic              busy,
  output logic              done
);
  dp_strobe_t       strobe;
  logic [CNT_W-1:0] cntQ;
  logic             cntOne, cntZero, dirIn;
  logic [VEC_W-1:0] vecRdData;

  wfm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .rdyIn(rdyIn), .fifoEmpty(fifoEmpty),
    .fifoFull(fifoFull), .cntOne(cntOne), .cntZero(cntZero),
    .strobe(strobe), .ctlOut(ctlOut), .fifoStrobe(fifoStrobe),
    .busy(busy), .done(done), .dirIn(dirIn), .vecRdData(vecRdData)
  );

  wfm_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(regWrData),
    .cntQ(cntQ), .addrQ(addrOut), .cntOne(cntOne), .cntZero(cntZero)
  );

  always_comb begin
    regRdData = '0;
    if (regAddr == RA_COUNT) begin
      regRdData = REG_W'(cntQ);
    end else if (regAddr == RA_CTRL) begin
      regRdData = REG_W'({dirIn, done, busy});
    end else if (regAddr == RA_ADDR) begin
      regRdData = REG_W'(addrOut);
    end else if (regAddr[RA_W-1:IDX_W] == '0) begin
      regRdData = REG_W'(vecRdData);
    end
  end
endmodule

// File: tb/wfm_master_test.sv
module wfm_master_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [3:0]  regAddr = 4'd8;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [5:0]  rdyIn = '0;
  logic        fifoEmpty = 1'b0;
  logic        fifoFull = 1'b0;
  logic [5:0]  ctlOut;
  logic [8:0]  addrOut;
  logic        fifoStrobe, busy, done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  wfm_master uut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .rdyIn(rdyIn),
    .fifoEmpty(fifoEmpty), .fifoFull(fifoFull), .ctlOut(ctlOut),
    .addrOut(addrOut), .fifoStrobe(fifoStrobe), .busy(busy), .done(done)
  );

  // reference model state
  logic [27:0] mTab [8];
  logic [2:0]  mIdx;
  logic        mRun, mDone, mDir;
  logic [8:0]  mAddr;
  logic [31:0] mCnt;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [27:0] mkVec(input logic [5:0] ctl, input logic [5:0] mask,
      input logic [5:0] level, input bit anyM, input logic [2:0] nt, input logic [2:0] nf,
      input bit fifo, input bit adr, input bit last);
    return {last, adr, fifo, nf, nt, anyM, level, mask, ctl};
  endfunction

  function automatic bit mCond(input logic [27:0] v, input logic [5:0] r);
    logic [5:0] m;
    m = ~(r ^ v[17:12]) & v[11:6];
    return v[18] ? (|m) : (&(m | ~v[11:6]));
  endfunction

  function automatic logic [31:0] mRead(input logic [3:0] a);
    if (a == 4'd8) return mCnt;
    if (a == 4'd9) return {29'b0, mDir, mDone, mRun};
    if (a == 4'd10) return {23'b0, mAddr};
    if (a < 4'd8) return {4'b0, mTab[a[2:0]]};
    return 32'b0;
  endfunction

  task automatic mReset();
    for (int i = 0; i < 8; i++) mTab[i] = '0;
    mIdx = '0; mRun = 0; mDone = 0; mDir = 0; mAddr = '0; mCnt = '0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; regWr = 1'b0; regAddr = 4'd8;
    @(negedge clk);
    mReset();
    rstN = 1'b1;
  endtask

  // one cycle: drive at negedge, compare against model, advance model for the coming edge
  task automatic tick(input bit wr, input logic [3:0] a, input logic [31:0] d,
      input logic [5:0] r, input bit fe, input bit ff);
    logic [27:0] v;
    bit c, ok, stall, runOld;
    @(negedge clk);
    regWr = wr; regAddr = a; regWrData = d; rdyIn = r; fifoEmpty = fe; fifoFull = ff;
    #1;
    v = mTab[mIdx];
    c = mCond(v, r);
    ok = mDir ? !ff : !fe;
    stall = mRun && c && v[25] && !ok;
    chk("R3/R4/R5 ctlOut", 32'(ctlOut), mRun ? 32'(v[5:0]) : 32'h0);
    chk("R7 fifoStrobe", 32'(fifoStrobe), 32'(mRun && c && !stall && v[25]));
    chk("R6 addrOut", 32'(addrOut), 32'(mAddr));
    chk("R9 busy", 32'(busy), 32'(mRun));
    chk("R9 done", 32'(done), 32'(mDone));
    if (!wr) chk(a == 4'd8 ? "R10 count read" : "R2 register read", regRdData, mRead(a));
    runOld = mRun;
    if (mRun) begin
      if (!c) mIdx = v[24:22];
      else if (!stall) begin
        if (v[26]) mAddr = mAddr + 1'b1;
        if (v[27]) begin
          mIdx = '0;
          mCnt = mCnt - 1;
          if (mCnt == 0) begin mRun = 0; mDone = 1; end
        end else mIdx = v[21:19];
      end
    end
    if (wr) begin
      if (a < 4'd8) mTab[a[2:0]] = d[27:0];
      else if (!runOld) begin
        if (a == 4'd8) mCnt = d;
        else if (a == 4'd10) mAddr = d[8:0];
        else if (a == 4'd9) begin
          mDir = d[1];
          if (d[0]) begin
            if (mCnt == 0) mDone = 1;
            else begin mRun = 1; mIdx = '0; mDone = 0; end
          end
        end
      end
    end
  endtask

  task automatic wrReg(input logic [3:0] a, input logic [31:0] d);
    tick(1, a, d, '0, 0, 0);
  endtask

  task automatic idle(input logic [5:0] r, input bit fe, input bit ff);
    tick(0, 4'd8, 32'h0, r, fe, ff);
  endtask

  task automatic peek();
    @(posedge clk);
    #1;
  endtask

  initial begin : watchdog
    #1_500_000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd4242));
    mReset();
    doReset();

    // R1: reset state
    peek();
    chk("R1 ctlOut", 32'(ctlOut), 0);
    chk("R1 addrOut", 32'(addrOut), 0);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 fifoStrobe", 32'(fifoStrobe), 0);
    chk("R1 count", regRdData, 0);

    // R2: vector write and readback
    for (int i = 0; i < 8; i++) wrReg(4'(i), $urandom);
    for (int i = 0; i < 11; i++) tick(0, 4'(i), 0, '0, 0, 0);

    // R4: AND condition with wait
    wrReg(4'd0, {4'hF, mkVec(6'd1, 6'b000011, 6'b000001, 0, 3'd1, 3'd0, 0, 0, 0)});
    wrReg(4'd1, mkVec(6'd2, 6'd0, 6'd0, 0, 3'd0, 3'd0, 0, 0, 1));
    wrReg(4'd8, 32'd1);
    wrReg(4'd9, 32'd1);
    peek(); chk("R3 busy after go", 32'(busy), 1); chk("R3 ctl vec0", 32'(ctlOut), 1);
    idle(6'b000000, 0, 0); peek(); chk("R4 false stays", 32'(ctlOut), 1);
    idle(6'b000011, 0, 0); peek(); chk("R4 mismatch stays", 32'(ctlOut), 1);
    idle(6'b000101, 0, 0); peek(); chk("R4 match branches", 32'(ctlOut), 2);
    idle(6'b000000, 0, 0); peek(); chk("R9 done after last", 32'(done), 1);
    chk("R9 idle after last", 32'(busy), 0); chk("R3 idle ctl", 32'(ctlOut), 0);

    // R5: OR condition
    wrReg(4'd0, mkVec(6'd1, 6'b110000, 6'b100000, 1, 3'd1, 3'd0, 0, 0, 0));
    wrReg(4'd8, 32'd1);
    wrReg(4'd9, 32'd1);
    idle(6'b010000, 0, 0); peek(); chk("R5 none match", 32'(ctlOut), 1);
    idle(6'b000000, 0, 0); peek(); chk("R5 one match", 32'(ctlOut), 2);
    idle(6'b000000, 0, 0);

    // R8 / R7: stall in both directions
    wrReg(4'd0, mkVec(6'd1, 6'd0, 6'd0, 0, 3'd1, 3'd0, 1, 1, 0));
    wrReg(4'd10, 32'd3);
    wrReg(4'd8, 32'd1);
    wrReg(4'd9, 32'd1);
    idle('0, 1, 0); chk("R8 no strobe when empty", 32'(fifoStrobe), 0);
    peek(); chk("R8 held ctl", 32'(ctlOut), 1); chk("R8 held addr", 32'(addrOut), 3);
    idle('0, 0, 1); chk("R7 strobe out", 32'(fifoStrobe), 1);
    peek(); chk("R8 advanced", 32'(ctlOut), 2); chk("R6 addr step", 32'(addrOut), 4);
    idle('0, 0, 0);
    wrReg(4'd8, 32'd1);
    wrReg(4'd9, 32'd3);
    idle('0, 0, 1); chk("R8 no strobe when full", 32'(fifoStrobe), 0);
    peek(); chk("R8 held in-dir", 32'(ctlOut), 1);
    idle('0, 1, 0); chk("R7 strobe in", 32'(fifoStrobe), 1);
    idle('0, 0, 0);

    // R6 wrap, R9 restart, R10 remaining count
    wrReg(4'd0, mkVec(6'd5, 6'd0, 6'd0, 0, 3'd0, 3'd0, 0, 1, 1));
    wrReg(4'd10, 32'd511);
    wrReg(4'd8, 32'd2);
    wrReg(4'd9, 32'd1);
    idle('0, 0, 0); peek();
    chk("R6 wrap", 32'(addrOut), 0); chk("R10 remaining", regRdData, 1);
    chk("R9 restart busy", 32'(busy), 1);
    idle('0, 0, 0); peek();
    chk("R6 after wrap", 32'(addrOut), 1); chk("R9 done", 32'(done), 1);

    // R11: go with zero count
    wrReg(4'd8, 32'd0);
    wrReg(4'd9, 32'd1);
    peek(); chk("R11 done", 32'(done), 1); chk("R11 not busy", 32'(busy), 0);

    // R12: writes ignored while busy
    wrReg(4'd0, mkVec(6'd7, 6'd0, 6'd0, 1, 3'd0, 3'd0, 0, 0, 0));
    wrReg(4'd10, 32'd20);
    wrReg(4'd8, 32'd5);
    wrReg(4'd9, 32'd1);
    wrReg(4'd8, 32'd9); peek(); chk("R12 count kept", regRdData, 5);
    wrReg(4'd10, 32'd100); peek(); chk("R12 addr kept", 32'(addrOut), 20);
    wrReg(4'd9, 32'd2); peek(); chk("R12 dir kept", regRdData, 32'h1);
    doReset();

    // random programs against the model
    for (int p = 0; p < 14; p++) begin
      for (int i = 0; i < 8; i++) begin
        logic [5:0] mk;
        bit anyM;
        mk = 6'($urandom & $urandom & $urandom);
        anyM = (mk != 0) && ($urandom % 2 == 1);
        wrReg(4'(i), {4'($urandom), mkVec(6'($urandom), mk, 6'($urandom), anyM,
          3'(i + 1), 3'($urandom), $urandom % 2 == 1, $urandom % 2 == 1,
          (i == 7) || ($urandom % 4 == 0))});
      end
      wrReg(4'd10, $urandom);
      wrReg(4'd8, 32'($urandom % 4 + 1));
      wrReg(4'd9, {30'b0, 1'($urandom), 1'b1});
      for (int c = 0; c < 3000 && mRun; c++)
        tick(0, 4'($urandom % 11), 0, 6'($urandom), $urandom % 4 == 0, $urandom % 4 == 0);
      idle('0, 0, 0);
      if (mRun) doReset();
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule